// File: doc/BRIEF.md
# Vector Bitwise Logic Unit

This block carries out whole-register bitwise operations on 128-bit vector operands for a vector execution pipeline. It takes a 32-bit instruction word, pulls the three 5-bit register index fields out of it, and presents them as combinational outputs. The register file uses these indices to return the two source vectors and the current contents of the destination register in the same cycle. The block then selects one of seven operations: four plain two-input logic functions, and three bit-merge functions in which the old destination value is a third operand.

The result and the destination index are registered one clock after an accepted instruction and marked by a one-cycle valid strobe. A 32-bit mask records which vector registers have been written. One bit is set per completed operation, but only while the tracking control input is high. An instruction word that does not decode to one of the seven operations raises a one-cycle illegal strobe instead of a result. Such a word never touches the mask.

Top module: `vec_logic_unit`

## Requirements
- R1: An instruction accepted with `in_valid` high at a rising edge produces `out_valid` high for exactly the following cycle, with `out_data` holding the result and `out_wd` holding the destination index. In cycles without an accepted legal instruction, `out_valid` is low and `out_data` / `out_wd` keep their last values.
- R2: The index outputs decode the instruction fields combinationally: `idx_t` = bits [20:16], `idx_s` = bits [15:11], `idx_d` = bits [10:6].
- R3: An instruction is legal only when bits [31:26] equal 6'h1E, bits [5:0] equal 6'h1E, and bits [25:21] are in 0..6. The codes in bits [25:21] are 0 AND, 1 OR, 2 NOR, 3 XOR, 4 move-where-mask-set, 5 move-where-mask-clear, 6 select.
- R4: AND, OR and XOR give the bitwise function of `src_s` and `src_t` over all 128 bits. NOR gives ~(`src_s` | `src_t`).
- R5: Move-where-mask-set gives (`dst_old` & ~`src_t`) | (`src_s` & `src_t`).
- R6: Move-where-mask-clear gives (`dst_old` & `src_t`) | (`src_s` & ~`src_t`).
- R7: Select gives (`src_s` & ~`dst_old`) | (`src_t` & `dst_old`). The old destination is the per-bit selector, with a 1 choosing `src_t`.
- R8: A legal accepted instruction with `track_en` high sets bit `idx_d` of `modify_mask` at the same edge that loads the result. The other bits are unchanged, and no bit is ever cleared except by reset.
- R9: A legal accepted instruction with `track_en` low leaves `modify_mask` unchanged.
- R10: An illegal accepted instruction gives `illegal` high for exactly the following cycle with `out_valid` low. It leaves `modify_mask`, `out_data` and `out_wd` unchanged.
- R11: After synchronous active-low reset, `out_valid`, `illegal`, `out_data`, `out_wd` and `modify_mask` are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Instruction and operands valid this cycle |
| instr | input | 32 | Instruction word |
| track_en | input | 1 | Enables recording of written registers |
| src_s | input | 128 | First source vector (register idx_s) |
| src_t | input | 128 | Second source vector (register idx_t) |
| dst_old | input | 128 | Current contents of destination register idx_d |
| idx_s | output | 5 | Decoded first source index |
| idx_t | output | 5 | Decoded second source index |
| idx_d | output | 5 | Decoded destination index |
| out_valid | output | 1 | Result strobe, one cycle per legal instruction |
| out_data | output | 128 | Registered result vector |
| out_wd | output | 5 | Registered destination index |
| illegal | output | 1 | Strobe for an undecodable instruction |
| modify_mask | output | 32 | One bit per vector register, set on a tracked write |

## Verification
The hardest situation to reach is the mask after a long, mixed history. This includes tracked and untracked writes to the same index, illegal words that carry a wd field, and the edge indices 0 and 31. A single wrong bit there only shows after that exact sequence. The stimulus runs a long seeded random stream that mixes legal codes, out-of-range codes, wrong major and minor opcodes and a random tracking bit, on top of directed cases. The bench keeps its own model of the mask and compares the whole 32-bit value after every instruction. The merge operations are stressed with all-zero and all-ones selector vectors, where one operand must pass through unchanged.

// File: rtl/vlu_pkg.sv
// Package: shared field positions, opcode constants and operation type
// for the vector bitwise logic unit. Assumes a 32-bit instruction word.
package vlu_pkg;
    localparam int INSTR_W   = 32;
    localparam int IDX_W     = 5;
    localparam int CODE_W    = 5;
    localparam int OPC_W     = 6;
    localparam logic [OPC_W-1:0] MAJOR_VEC = 6'h1E;
    localparam logic [OPC_W-1:0] MINOR_VEC = 6'h1E;

    typedef enum logic [2:0] {
        OP_AND  = 3'd0,
        OP_OR   = 3'd1,
        OP_NOR  = 3'd2,
        OP_XOR  = 3'd3,
        OP_MVNZ = 3'd4,
        OP_MVZ  = 3'd5,
        OP_SEL  = 3'd6,
        OP_NONE = 3'd7
    } vlu_op_e;
endpackage

// File: rtl/vlu_decode.sv
// Decoder: splits the instruction word into register indices and maps
// the major/minor opcodes plus the code field onto an operation.
// Assumes purely combinational use; no state.
module vlu_decode
    import vlu_pkg::*;
(
    input  logic [INSTR_W-1:0] instr,
    output logic [IDX_W-1:0]   idx_t,
    output logic [IDX_W-1:0]   idx_s,
    output logic [IDX_W-1:0]   idx_d,
    output vlu_op_e            op,
    output logic               legal
);
    logic [OPC_W-1:0]  major;
    logic [OPC_W-1:0]  minor;
    logic [CODE_W-1:0] code;
    logic              class_ok;

    // Field extraction at fixed bit positions.
    always_comb begin
        major = instr[31:26];
        code  = instr[25:21];
        idx_t = instr[20:16];
        idx_s = instr[15:11];
        idx_d = instr[10:6];
        minor = instr[5:0];
    end

    // Operation mapping; anything outside the seven codes is illegal.
    always_comb begin
        class_ok = (major == MAJOR_VEC) && (minor == MINOR_VEC);
        op       = OP_NONE;
        legal    = 1'b0;
        if (class_ok) begin
            legal = 1'b1;
            case (code)
                5'd0:    op = OP_AND;
                5'd1:    op = OP_OR;
                5'd2:    op = OP_NOR;
                5'd3:    op = OP_XOR;
                5'd4:    op = OP_MVNZ;
                5'd5:    op = OP_MVZ;
                5'd6:    op = OP_SEL;
                default: begin
                    op    = OP_NONE;
                    legal = 1'b0;
                end
            endcase
        end
    end
endmodule

// File: rtl/vlu_logic.sv
// Datapath: computes the selected bitwise function lane by lane.
// Assumes VEC_W is a multiple of LANE_W; lanes are independent.
module vlu_logic
    import vlu_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 32
) (
    input  vlu_op_e          op,
    input  logic [VEC_W-1:0] vs,
    input  logic [VEC_W-1:0] vt,
    input  logic [VEC_W-1:0] vd,
    output logic [VEC_W-1:0] res
);
    localparam int LANES = VEC_W / LANE_W;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        logic [LANE_W-1:0] s, t, d, r;
        assign s = vs[g*LANE_W +: LANE_W];
        assign t = vt[g*LANE_W +: LANE_W];
        assign d = vd[g*LANE_W +: LANE_W];

        // Per-lane function select.
        always_comb begin
            case (op)
                OP_AND:  r = s & t;
                OP_OR:   r = s | t;
                OP_NOR:  r = ~(s | t);
                OP_XOR:  r = s ^ t;
                OP_MVNZ: r = (d & ~t) | (s & t);
                OP_MVZ:  r = (d & t) | (s & ~t);
                OP_SEL:  r = (s & ~d) | (t & d);
                default: r = '0;
            endcase
        end

        assign res[g*LANE_W +: LANE_W] = r;
    end
endmodule

// File: rtl/vlu_track.sv
// Write tracker: one sticky bit per vector register, set when an update
// names that register. Assumes NREGS is a power of two; reset clears all.
module vlu_track #(
    parameter int NREGS = 32,
    localparam int IW   = $clog2(NREGS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             upd,
    input  logic [IW-1:0]    idx,
    output logic [NREGS-1:0] mask
);
    for (genvar g = 0; g < NREGS; g++) begin : g_bit
        // Sticky set of bit g on a matching update.
        always_ff @(posedge clk) begin
            if (!rst_n)
                mask[g] <= 1'b0;
            else if (upd && (idx == IW'(g)))
                mask[g] <= 1'b1;
        end
    end
endmodule

// File: rtl/vec_logic_unit.sv
// Top: decodes the instruction, computes the bitwise result, registers it
// with the destination index one cycle later, and records tracked writes.
// Assumes the register file returns operands in the cycle of in_valid.
module vec_logic_unit
    import vlu_pkg::*;
#(
    parameter int VEC_W  = 128,
    parameter int LANE_W = 32,
    parameter int NREGS  = 32
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               in_valid,
    input  logic [INSTR_W-1:0] instr,
    input  logic               track_en,
    input  logic [VEC_W-1:0]   src_s,
    input  logic [VEC_W-1:0]   src_t,
    input  logic [VEC_W-1:0]   dst_old,
    output logic [IDX_W-1:0]   idx_s,
    output logic [IDX_W-1:0]   idx_t,
    output logic [IDX_W-1:0]   idx_d,
    output logic               out_valid,
    output logic [VEC_W-1:0]   out_data,
    output logic [IDX_W-1:0]   out_wd,
    output logic               illegal,
    output logic [NREGS-1:0]   modify_mask
);
    vlu_op_e          op;
    logic             legal;
    logic [VEC_W-1:0] res;
    logic             accept;

    vlu_decode u_dec (
        .instr (instr),
        .idx_t (idx_t),
        .idx_s (idx_s),
        .idx_d (idx_d),
        .op    (op),
        .legal (legal)
    );

    vlu_logic #(.VEC_W(VEC_W), .LANE_W(LANE_W)) u_logic (
        .op  (op),
        .vs  (src_s),
        .vt  (src_t),
        .vd  (dst_old),
        .res (res)
    );

    assign accept = in_valid && legal;

    vlu_track #(.NREGS(NREGS)) u_track (
        .clk   (clk),
        .rst_n (rst_n),
        .upd   (accept && track_en),
        .idx   (idx_d),
        .mask  (modify_mask)
    );

    // Strobes: one-cycle result or illegal indication.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            illegal   <= 1'b0;
        end else begin
            out_valid <= accept;
            illegal   <= in_valid && !legal;
        end
    end

    // Result register: loads only on a legal accepted instruction.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_data <= '0;
            out_wd   <= '0;
        end else if (accept) begin
            out_data <= res;
            out_wd   <= idx_d;
        end
    end
endmodule

// File: rtl/vlu_checker.sv
// Checker: temporal properties on the unit's ports, bound to every instance.
module vlu_checker #(
    parameter int VEC_W = 128,
    parameter int NREGS = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             track_en,
    input logic             out_valid,
    input logic             illegal,
    input logic [VEC_W-1:0] out_data,
    input logic [4:0]       out_wd,
    input logic [NREGS-1:0] modify_mask
);
    AST_RESULT_FOLLOWS_INPUT: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> $past(in_valid)); // R1
    AST_IDLE_HOLDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(in_valid) |-> (!out_valid && !illegal && $stable(out_data))); // R1
    AST_STROBES_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        !(out_valid && illegal)); // R10
    AST_ILLEGAL_KEEPS_STATE: assert property (@(posedge clk) disable iff (!rst_n)
        illegal |-> ($stable(modify_mask) && $stable(out_data) && $stable(out_wd))); // R10
    AST_MASK_NEVER_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(modify_mask) & ~modify_mask) == '0)); // R8
    AST_TRACKED_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && $past(track_en)) |-> modify_mask[out_wd]); // R8
    AST_UNTRACKED_NO_CHANGE: assert property (@(posedge clk) disable iff (!rst_n)
        $past(in_valid && !track_en) |-> $stable(modify_mask)); // R9
endmodule

bind vec_logic_unit vlu_checker #(.VEC_W(VEC_W), .NREGS(NREGS)) u_vlu_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .in_valid    (in_valid),
    .track_en    (track_en),
    .out_valid   (out_valid),
    .illegal     (illegal),
    .out_data    (out_data),
    .out_wd      (out_wd),
    .modify_mask (modify_mask)
);

// File: tb/tb_vec_logic_unit.sv
`timescale 1ns/1ps
module tb_vec_logic_unit;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         in_valid = 1'b0;
    logic [31:0]  instr = '0;
    logic         track_en = 1'b0;
    logic [127:0] src_s = '0, src_t = '0, dst_old = '0;
    logic [4:0]   idx_s, idx_t, idx_d, out_wd;
    logic         out_valid, illegal;
    logic [127:0] out_data;
    logic [31:0]  modify_mask;

    int n_cmp = 0;
    int n_bad = 0;
    logic [127:0] exp_data = '0;
    logic [4:0]   exp_wd = '0;
    logic [31:0]  exp_mask = '0;

    always #10 clk = ~clk;

    vec_logic_unit dut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .instr(instr),
        .track_en(track_en), .src_s(src_s), .src_t(src_t), .dst_old(dst_old),
        .idx_s(idx_s), .idx_t(idx_t), .idx_d(idx_d), .out_valid(out_valid),
        .out_data(out_data), .out_wd(out_wd), .illegal(illegal),
        .modify_mask(modify_mask)
    );

    task automatic chk(input bit ok, input string req,
                       input logic [127:0] act, input logic [127:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [127:0] ref_res(input int code,
            input logic [127:0] s, input logic [127:0] t, input logic [127:0] d);
        case (code)
            0: return s & t;
            1: return s | t;
            2: return ~(s | t);
            3: return s ^ t;
            4: return (d & ~t) | (s & t);
            5: return (d & t) | (s & ~t);
            6: return (s & ~d) | (t & d);
            default: return '0;
        endcase
    endfunction

    function automatic string op_req(input int code);
        if (code < 4) return "R4";
        if (code == 4) return "R5";
        if (code == 5) return "R6";
        return "R7";
    endfunction

    function automatic logic [127:0] rnd128();
        return {$urandom, $urandom, $urandom, $urandom};
    endfunction

    // Drive one instruction at a falling edge, check the result a cycle later.
    task automatic run_op(input logic [5:0] maj, input logic [4:0] code,
            input logic [4:0] t, input logic [4:0] s, input logic [4:0] d,
            input logic [5:0] mn, input logic [127:0] vs, input logic [127:0] vt,
            input logic [127:0] vd, input bit trk);
        bit legal;
        legal    = (maj == 6'h1E) && (mn == 6'h1E) && (code < 5'd7);
        instr    = {maj, code, t, s, d, mn};
        src_s    = vs;
        src_t    = vt;
        dst_old  = vd;
        track_en = trk;
        in_valid = 1'b1;
        #1;
        chk(idx_t == t && idx_s == s && idx_d == d, "R2",
            {idx_t, idx_s, idx_d}, {t, s, d});
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        if (legal) begin
            exp_data = ref_res(int'(code), vs, vt, vd);
            exp_wd   = d;
            if (trk) exp_mask[d] = 1'b1;
        end
        chk(out_valid == legal, legal ? "R1" : "R10", out_valid, legal);
        chk(illegal == !legal, legal ? "R3" : "R3 R10", illegal, !legal);
        chk(out_data == exp_data, legal ? op_req(int'(code)) : "R10", out_data, exp_data);
        chk(out_wd == exp_wd, legal ? "R1" : "R10", out_wd, exp_wd);
        chk(modify_mask == exp_mask, !legal ? "R10" : (trk ? "R8" : "R9"),
            modify_mask, exp_mask);
    endtask

    task automatic idle_cycle();
        @(posedge clk);
        @(negedge clk);
        chk(!out_valid && !illegal, "R1 idle strobes", {out_valid, illegal}, 0);
        chk(out_data == exp_data && out_wd == exp_wd, "R1 idle hold", out_data, exp_data);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [127:0] ones;
        ones = '1;
        void'($urandom(32'h5EED_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R11 reset values
        chk(!out_valid && !illegal, "R11", {out_valid, illegal}, 0);
        chk(out_data == '0 && out_wd == '0, "R11", out_data, 0);
        chk(modify_mask == '0, "R11", modify_mask, 0);

        // R4 plain functions on fixed patterns
        for (int c = 0; c < 4; c++)
            run_op(6'h1E, 5'(c), 5'd3, 5'd9, 5'd12, 6'h1E,
                   {4{32'hF0F0_A5A5}}, {4{32'hFF00_3C3C}}, '0, 1'b1);
        // R5: zero selector keeps old destination, all-ones takes source
        run_op(6'h1E, 5'd4, 5'd1, 5'd2, 5'd0, 6'h1E, rnd128(), '0, {4{32'hDEAD_BEEF}}, 1'b1);
        run_op(6'h1E, 5'd4, 5'd1, 5'd2, 5'd31, 6'h1E, {4{32'h1234_5678}}, ones, rnd128(), 1'b0);
        // R6: all-ones selector keeps destination, zero takes source
        run_op(6'h1E, 5'd5, 5'd4, 5'd5, 5'd6, 6'h1E, rnd128(), ones, {4{32'hCAFE_F00D}}, 1'b1);
        run_op(6'h1E, 5'd5, 5'd4, 5'd5, 5'd7, 6'h1E, {4{32'h0BAD_CAFE}}, '0, rnd128(), 1'b1);
        // R7: destination as selector, zero picks s, ones picks t
        run_op(6'h1E, 5'd6, 5'd8, 5'd9, 5'd10, 6'h1E, {4{32'h1111_2222}}, rnd128(), '0, 1'b1);
        run_op(6'h1E, 5'd6, 5'd8, 5'd9, 5'd11, 6'h1E, rnd128(), {4{32'h3333_4444}}, ones, 1'b0);
        idle_cycle();
        // R3/R10: out-of-range code, wrong minor, wrong major, wd pointing at clear bit
        run_op(6'h1E, 5'd7, 5'd1, 5'd1, 5'd20, 6'h1E, rnd128(), rnd128(), rnd128(), 1'b1);
        run_op(6'h1E, 5'd31, 5'd1, 5'd1, 5'd21, 6'h1E, rnd128(), rnd128(), rnd128(), 1'b1);
        run_op(6'h1E, 5'd0, 5'd1, 5'd1, 5'd22, 6'h1D, rnd128(), rnd128(), rnd128(), 1'b1);
        run_op(6'h1F, 5'd1, 5'd1, 5'd1, 5'd23, 6'h1E, rnd128(), rnd128(), rnd128(), 1'b1);
        idle_cycle();
        // R8 boundary: index 31 tracked after the untracked write
        run_op(6'h1E, 5'd3, 5'd0, 5'd0, 5'd31, 6'h1E, rnd128(), rnd128(), rnd128(), 1'b1);

        // Random mix of legal and illegal words, random tracking.
        for (int i = 0; i < 400; i++) begin
            logic [5:0] maj, mn;
            logic [4:0] code;
            int sel;
            sel  = $urandom_range(0, 9);
            maj  = (sel == 0) ? 6'($urandom) : 6'h1E;
            mn   = (sel == 1) ? 6'($urandom) : 6'h1E;
            code = (sel == 2) ? 5'($urandom) : 5'($urandom_range(0, 6));
            run_op(maj, code, 5'($urandom), 5'($urandom), 5'($urandom), mn,
                   rnd128(), rnd128(), rnd128(), ($urandom_range(0, 3) != 0));
            if ($urandom_range(0, 7) == 0) idle_cycle();
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule